// File: doc/BRIEF.md
# Lockable Watchdog Control Register

This block is the control register of a watchdog timer, paired with the timer's counting core. Software reaches the register over a simple write/read bus. Four control bits live in the low nibble: an enable, a count-source select, a lock and a change-guard. Each bit has its own rule for when a write may change it. Once the lock is set it stays set, and it freezes the count-source and guard bits. The enable bit can only ever be set, and it can be set even while the register is locked.

When the guard bit is set, a write is accepted only inside a short window that opens after a key byte arrives on a separate key port. The block drives enable, mode, lock and guard outputs to the rest of the watchdog. Its counter advances either every clock cycle or only on cycles that retire an instruction. A kick clears the counter. When the counter reaches its limit it raises a one-cycle timeout pulse and starts again from zero.

Top module: `wdt_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00 and all outputs are low. Bits 7:4 of a read at the register offset (default 0x0) are always zero.
- R2: With lock and guard clear, a write at the register offset stores its bit 1 as the mode and its bit 3 as the guard. A read returns them in those positions, together with enable in bit 0 and lock in bit 2.
- R3: The lock bit (bit 2) is set by an accepted write of 1. Once set, it stays 1 until reset.
- R4: While lock is 1, accepted writes leave the mode and guard bits unchanged.
- R5: The enable bit (bit 0) is set by an accepted write of 1, including while locked. Writing 0 never clears it; only reset does.
- R6: A key strobe carrying 0xD8 opens a window covering the 4 cycles after the key cycle. A key with any other value opens nothing. The key cycle itself is not inside the window.
- R7: While guard is 1, a write outside the window changes no bit.
- R8: The counter holds its value while enable is 0. A kick clears it to 0, and a kick takes priority over counting.
- R9: With mode 0 the counter advances every cycle. With mode 1 it advances only on cycles where the instruction-retired strobe is high.
- R10: When an advance would bring the counter to TIMEOUT, the counter returns to 0 and timeout is high for exactly one cycle.
- R11: A single accepted write that sets lock and changes mode applies the mode change, because the lock gate uses the value held before the write.
- R12: Writes to any other address are ignored, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data |
| key_valid | input | 1 | Key strobe |
| key_data | input | 8 | Key byte |
| instr_retired | input | 1 | One instruction retired this cycle |
| kick | input | 1 | Clear the counter |
| wdt_enable | output | 1 | Enable bit |
| wdt_mode | output | 1 | Count source: 0 clock, 1 instructions |
| wdt_locked | output | 1 | Lock bit |
| wdt_protect | output | 1 | Guard bit |
| count | output | CNT_W | Counter value |
| timeout | output | 1 | One-cycle timeout pulse |

## Verification
The hardest situations to reach are the edges of the key window. The bench checks a write in the last open cycle, a write one cycle later, and a write in the same cycle as the key. It also covers the case where one write both sets lock and changes mode. Directed sequences place a key strobe, wait an exact number of idle cycles and then write. A second reset gives a locked-but-disabled state in which enable is then set.

A long stretch of random writes, keys, kicks and retire strobes follows. Throughout, a behavioural model predicts every output on every clock.

// File: rtl/wdt_ctrl_pkg.sv
package wdt_ctrl_pkg;
    localparam int REG_W  = 8;
    localparam int CTRL_W = 4;

    // field order matches the register bit positions 3..0
    typedef struct packed {
        logic guard;   // bit 3
        logic lock;    // bit 2
        logic mode;    // bit 1
        logic enable;  // bit 0
    } ctrl_bits_t;
endpackage

// File: rtl/wdt_unlock_window.sv
module wdt_unlock_window #(
    parameter logic [7:0] KEY    = 8'hD8,
    parameter int         WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_valid,
    input  logic [7:0] key_data,
    output logic       open
);
    localparam int RW = $clog2(WINDOW + 1);
    localparam logic [RW-1:0] FULL = RW'(WINDOW);

    typedef struct packed {
        logic [RW-1:0] remain;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_valid && key_data == KEY) begin
            st_d.remain = FULL;
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open = (st_q.remain != '0);

    assert_window_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.remain <= FULL);
    assert_window_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> (st_q.remain <= FULL - 1'b1));
endmodule

// File: rtl/wdt_ctrl_bits.sv
module wdt_ctrl_bits
    import wdt_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_strobe,
    input  ctrl_bits_t wr_bits,
    output ctrl_bits_t bits
);
    ctrl_bits_t bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (wr_strobe) begin
            bits_d.enable = bits_q.enable | wr_bits.enable;
            bits_d.lock   = bits_q.lock   | wr_bits.lock;
            if (!bits_q.lock) begin
                bits_d.mode  = wr_bits.mode;
                bits_d.guard = wr_bits.guard;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits = bits_q;

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q.lock |=> bits_q.lock);
    assert_frozen_when_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q.lock |=> ($stable(bits_q.mode) && $stable(bits_q.guard)));
    assert_enable_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q.enable |=> bits_q.enable);
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |=> $stable(bits_q));
endmodule

// File: rtl/wdt_count_engine.sv
module wdt_count_engine #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] TIMEOUT = 16'd1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode,
    input  logic             instr_retired,
    input  logic             kick,
    output logic [CNT_W-1:0] count,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] LAST = TIMEOUT - 1'b1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        step       = enable && (!mode || instr_retired);
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (kick) begin
            st_d.count = '0;
        end else if (step) begin
            if (st_q.count == LAST) begin
                st_d.count = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.count;
    assign timeout = st_q.pulse;

    assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !kick) |=> $stable(st_q.count));
    assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (st_q.count == '0 && !st_q.pulse));
    assert_instr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !instr_retired && !kick) |=> $stable(st_q.count));
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);
    assert_wrap_on_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> st_q.count == '0);
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_ctrl_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] REG_OFFSET = '0,
    parameter logic [7:0]        KEY        = 8'hD8,
    parameter int                WINDOW     = 4,
    parameter int                CNT_W      = 16,
    parameter logic [CNT_W-1:0]  TIMEOUT    = 16'd1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              key_valid,
    input  logic [7:0]        key_data,
    input  logic              instr_retired,
    input  logic              kick,
    output logic              wdt_enable,
    output logic              wdt_mode,
    output logic              wdt_locked,
    output logic              wdt_protect,
    output logic [CNT_W-1:0]  count,
    output logic              timeout
);
    localparam int PAD_W = REG_W - CTRL_W;

    ctrl_bits_t bits;
    ctrl_bits_t wr_bits;
    logic       win_open;
    logic       hit;
    logic       accept;
    logic       unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:CTRL_W];
    assign wr_bits   = ctrl_bits_t'(wr_data[CTRL_W-1:0]);
    assign hit       = wr_en && (wr_addr == REG_OFFSET);
    assign accept    = hit && (!bits.guard || win_open);

    wdt_unlock_window #(.KEY(KEY), .WINDOW(WINDOW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_data  (key_data),
        .open      (win_open)
    );

    wdt_ctrl_bits u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (accept),
        .wr_bits   (wr_bits),
        .bits      (bits)
    );

    wdt_count_engine #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (bits.enable),
        .mode          (bits.mode),
        .instr_retired (instr_retired),
        .kick          (kick),
        .count         (count),
        .timeout       (timeout)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == REG_OFFSET) begin
            rd_data = {{PAD_W{1'b0}}, bits};
        end
    end

    assign wdt_enable  = bits.enable;
    assign wdt_mode    = bits.mode;
    assign wdt_locked  = bits.lock;
    assign wdt_protect = bits.guard;

    assert_guarded_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bits.guard && !win_open) |=> $stable(bits));
    assert_other_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(bits));
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:CTRL_W] == '0);
endmodule

// File: tb/wdt_ctrl_reg_test.sv
module wdt_ctrl_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int TMO = 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          key_valid = 1'b0;
    logic [7:0]    key_data = '0;
    logic          instr_retired = 1'b0;
    logic          kick = 1'b0;
    logic          wdt_enable, wdt_mode, wdt_locked, wdt_protect, timeout;
    logic [15:0]   count;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit m_en, m_mode, m_lock, m_ccp, m_to;
    int m_win, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_ctrl_reg #(.ADDR_W(AW), .TIMEOUT(16'(TMO))) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .key_valid(key_valid), .key_data(key_data),
        .instr_retired(instr_retired), .kick(kick),
        .wdt_enable(wdt_enable), .wdt_mode(wdt_mode), .wdt_locked(wdt_locked),
        .wdt_protect(wdt_protect), .count(count), .timeout(timeout)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int model_rd();
        if (rd_addr != 0) return 0;
        return {m_ccp, m_lock, m_mode, m_en};
    endfunction

    task automatic compare_all();
        check("R2 rd_data", rd_data, model_rd());
        check("R5 enable", wdt_enable, m_en);
        check("R9 mode", wdt_mode, m_mode);
        check("R3 lock", wdt_locked, m_lock);
        check("R7 protect", wdt_protect, m_ccp);
        check("R8 count", count, m_cnt);
        check("R10 timeout", timeout, m_to);
    endtask

    task automatic tick();
        bit acc, n_en, n_mode, n_lock, n_ccp, n_to;
        int n_win, n_cnt;
        acc = wr_en && wr_addr == 0 && (!m_ccp || m_win > 0);
        n_en = m_en; n_mode = m_mode; n_lock = m_lock; n_ccp = m_ccp;
        if (acc) begin
            n_en   = m_en | wr_data[0];
            n_lock = m_lock | wr_data[2];
            if (!m_lock) begin
                n_mode = wr_data[1];
                n_ccp  = wr_data[3];
            end
        end
        if (key_valid && key_data == 8'hD8) n_win = 4;
        else n_win = (m_win > 0) ? m_win - 1 : 0;
        n_cnt = m_cnt; n_to = 0;
        if (kick) n_cnt = 0;
        else if (m_en && (!m_mode || instr_retired)) begin
            if (m_cnt == TMO - 1) begin n_cnt = 0; n_to = 1; end
            else n_cnt = m_cnt + 1;
        end
        @(posedge clk);
        #1;
        m_en = n_en; m_mode = n_mode; m_lock = n_lock; m_ccp = n_ccp;
        m_win = n_win; m_cnt = n_cnt; m_to = n_to;
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 0; key_valid = 0; kick = 0; instr_retired = 0; rd_addr = '0;
        repeat (2) @(posedge clk);
        #2;
        m_en = 0; m_mode = 0; m_lock = 0; m_ccp = 0; m_win = 0; m_cnt = 0; m_to = 0;
        check("R1 reset rd_data", rd_data, 0);
        check("R1 reset timeout", timeout, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(logic [7:0] d, logic [AW-1:0] a = '0);
        wr_en = 1; wr_data = d; wr_addr = a;
        tick();
        wr_en = 0; wr_addr = '0;
    endtask

    task automatic send_key(logic [7:0] k);
        key_valid = 1; key_data = k;
        tick();
        key_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2: mode bit written while disabled; R8 counter holds
        wr(8'hF2);
        check("R1 upper bits zero", rd_data, 8'h02);
        instr_retired = 1; idle(5); instr_retired = 0;
        check("R8 hold while disabled", count, 0);
        wr(8'h00);

        // R12: other address ignored, other read zero
        wr(8'h0F, 4'd3);
        check("R12 write elsewhere ignored", rd_data, 0);
        wr(8'h01);
        rd_addr = 4'd5; tick();
        check("R12 read elsewhere zero", rd_data, 0);
        rd_addr = '0;

        // R9 clock mode counting, R8 kick
        idle(10);
        kick = 1; tick(); kick = 0;
        check("R8 kick clears", count, 0);
        wr(8'h00);
        check("R5 enable not cleared", wdt_enable, 1);

        // R9 instruction mode, R10 timeout
        wr(8'h03);
        for (int i = 0; i < 90; i++) begin
            instr_retired = i[0]; tick();
        end
        instr_retired = 0;
        wr(8'h01);
        idle(2 * TMO);

        // R7 guard on, R6 window edges
        wr(8'h0B);
        wr(8'h09);
        check("R7 write dropped", wdt_mode, 1);
        send_key(8'h55);
        wr(8'h09);
        check("R6 wrong key", wdt_mode, 1);
        key_valid = 1; key_data = 8'hD8; wr(8'h09); key_valid = 0;
        check("R6 key cycle not open", wdt_mode, 1);
        idle(3);
        wr(8'h0B);
        check("R6 window 4th cycle", wdt_mode, 1);
        send_key(8'hD8);
        idle(3);
        wr(8'h09);
        check("R6 last open cycle", wdt_mode, 0);
        send_key(8'hD8);
        idle(4);
        wr(8'h0B);
        check("R6 closed after window", wdt_mode, 0);

        // R11 lock and mode change together
        send_key(8'hD8);
        wr(8'h0F);
        check("R11 mode applied with lock", rd_data, 8'h0F);
        send_key(8'hD8);
        wr(8'h01);
        check("R4 mode and guard frozen", rd_data, 8'h0F);
        check("R3 lock kept", wdt_locked, 1);

        // R5 enable set while locked
        do_reset();
        wr(8'h04);
        wr(8'h03);
        check("R5 enable while locked", rd_data, 8'h05);

        // random stretch
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom_range(0, 7) == 0);
            wr_addr = ($urandom_range(0, 5) == 0) ? 4'd1 : 4'd0;
            wr_data = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0) wr_data[2] = 1'b0;
            key_valid = ($urandom_range(0, 9) == 0);
            key_data = ($urandom_range(0, 1) == 0) ? 8'hD8 : 8'($urandom_range(0, 255));
            instr_retired = $urandom_range(0, 1) == 1;
            kick = ($urandom_range(0, 60) == 0);
            rd_addr = ($urandom_range(0, 7) == 0) ? 4'd2 : 4'd0;
            tick();
            if (i % 700 == 699) do_reset();
        end
        wr_en = 0; key_valid = 0; kick = 0;

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule